// File: doc/BRIEF.md
# Multi-Cycle Register-File Processor

A compact 8-bit processor that executes a small fixed instruction set one instruction at a time. Each instruction takes four clock cycles: two fetch cycles that read the two instruction bytes, one decode cycle that latches the source operands from an eight-entry register file, and one execute cycle. No instruction overlaps another. Instructions, data, the call stack and memory-mapped I/O all sit in one address space. That space is reached over a single port: an address driven only by the processor, a read-data input and a write-data output with a write strobe.

An instruction has two bytes. Byte 0 holds the opcode in bits [7:4]. Its bits [2:0] name the destination register, or the register stored by a store. Its bits [1:0] pick the flag tested by a conditional jump. For ALU operations, byte 1 holds the first source register in bits [5:3] and the second source in bits [2:0]. NOT and MOV use bits [5:3] as their only source. Load, store, jump and call instructions use all of byte 1 as an 8-bit address. Opcodes: ADD=0, SUB=1, AND=2, OR=3, NOT=4, MOV=5, LDR=6, STR=7, JMP=8, JX=9, JNX=10, CALL=11, RET=12, HLT=15. Opcodes 13 and 14 do nothing. The flag register has four bits: zero in bit 0, carry in bit 1, negative in bit 2 and overflow in bit 3. The flag index of JX and JNX counts in the same order.

Top module: `regfile_cpu`

## Requirements
- R1: Each instruction takes exactly four cycles. In the first cycle the address equals the program counter, in the second cycle it equals the program counter plus one, and the write strobe is low in both of these cycles and in the decode cycle.
- R2: Reset is synchronous and active high. It clears the program counter, every register and every flag, sets the stack pointer to 0xFF, and leaves the processor in its first fetch cycle with the halted output low.
- R3: ADD and SUB write rs1+rs2 or rs1-rs2 (mod 256) to rd. Zero and negative follow the result. Carry is the unsigned carry-out for ADD and the borrow (rs1<rs2) for SUB. Overflow is two's-complement overflow.
- R4: AND, OR and NOT write the bitwise result to rd, set zero and negative from it, and clear carry and overflow.
- R5: LDR puts the byte at the address in byte 1 on the address bus during execute and writes that byte to rd. STR drives that address with the write strobe high and the value of the register named in byte 0 bits [2:0]. MOV copies rs1 into rd.
- R6: JMP loads the byte-1 address into the program counter, so the next fetch reads from that address.
- R7: JX jumps when the selected flag is 1, and JNX jumps when it is 0. Otherwise the next fetch reads the instruction that follows.
- R8: CALL decrements the stack pointer and writes the return address (the address after the CALL) to the new stack pointer, then jumps. RET reads the byte at the stack pointer into the program counter, then increments the stack pointer.
- R9: After HLT is executed, the halted output goes high and stays high, the write strobe stays low, and no further fetch takes place.
- R10: Only ADD, SUB, AND, OR and NOT change the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Address of the current memory or I/O access |
| mem_rdata | input | 8 | Read data; must reflect mem_addr within the same cycle |
| mem_wdata | output | 8 | Write data, valid while mem_we is high |
| mem_we | output | 1 | Write strobe; the memory captures mem_wdata at the rising edge |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions assume that memory read data is combinational: whatever sits at the driven address is present in the same cycle. The bench memory model reads this way and never stalls. The assertions also assume that reset is held for at least one clock edge before the first instruction. The stimulus holds reset for three edges, preloads the program and data before release, and places code, operand data, result slots and the stack in separate regions. This keeps stores and pushes from overwriting instructions. Every branch has a halt placed on its wrong path, so a branch that goes the wrong way stops the run early.

// File: rtl/regfile_cpu.sv
module regfile_cpu #(
  parameter int W      = 8,
  parameter int NREG   = 8,
  parameter logic [W-1:0] SP_TOP = '1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic         halted
);
  localparam int RB = $clog2(NREG);

  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
                         OP_NOT = 4'd4, OP_MOV = 4'd5, OP_LDR = 4'd6, OP_STR = 4'd7,
                         OP_JMP = 4'd8, OP_JX = 4'd9, OP_JNX = 4'd10, OP_CALL = 4'd11,
                         OP_RET = 4'd12, OP_HLT = 4'd15;

  typedef enum logic [2:0] {S_F0, S_F1, S_DEC, S_EX, S_HALT} state_t;

  state_t         state;
  logic [W-1:0]   pc, sp, ir0, ir1, opa, opb;
  logic [W-1:0]   rf [NREG];
  logic [3:0]     flags;

  wire [3:0]    op   = ir0[7:4];
  wire [RB-1:0] rd   = ir0[RB-1:0];
  wire [RB-1:0] rs1  = ir1[2*RB-1:RB];
  wire [RB-1:0] rs2  = ir1[RB-1:0];
  wire [1:0]    fsel = ir0[1:0];
  wire          is_alu = (op <= OP_NOT);
  wire          cond = flags[fsel];
  wire          take = (op == OP_JX && cond) || (op == OP_JNX && !cond);
  wire          in_ex = (state == S_EX);

  logic [W-1:0] res;
  logic         cy, ov;
  always_comb begin
    res = '0; cy = 1'b0; ov = 1'b0;
    case (op)
      OP_ADD: begin
        {cy, res} = {1'b0, opa} + {1'b0, opb};
        ov = (opa[W-1] == opb[W-1]) && (res[W-1] != opa[W-1]);
      end
      OP_SUB: begin
        {cy, res} = {1'b0, opa} - {1'b0, opb};
        ov = (opa[W-1] != opb[W-1]) && (res[W-1] != opa[W-1]);
      end
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_NOT:  res = ~opa;
      default: res = '0;
    endcase
  end

  always_comb begin
    mem_addr = pc;
    if (in_ex) begin
      case (op)
        OP_LDR, OP_STR: mem_addr = ir1;
        OP_CALL:        mem_addr = sp - 1'b1;
        OP_RET:         mem_addr = sp;
        default:        mem_addr = pc;
      endcase
    end
  end

  assign mem_we    = in_ex && (op == OP_STR || op == OP_CALL);
  assign mem_wdata = (op == OP_CALL) ? pc : opa;
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_F0;
      pc    <= '0;
      sp    <= SP_TOP;
      ir0   <= '0;
      ir1   <= '0;
      opa   <= '0;
      opb   <= '0;
      flags <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_F0: begin ir0 <= mem_rdata; pc <= pc + 1'b1; state <= S_F1; end
        S_F1: begin ir1 <= mem_rdata; pc <= pc + 1'b1; state <= S_DEC; end
        S_DEC: begin
          opa   <= (op == OP_STR) ? rf[rd] : rf[rs1];
          opb   <= rf[rs2];
          state <= S_EX;
        end
        S_EX: begin
          state <= S_F0;
          if (is_alu) begin
            rf[rd] <= res;
            flags  <= {ov, res[W-1], cy, res == '0};
          end
          case (op)
            OP_MOV:  rf[rd] <= opa;
            OP_LDR:  rf[rd] <= mem_rdata;
            OP_JMP:  pc <= ir1;
            OP_JX, OP_JNX: if (take) pc <= ir1;
            OP_CALL: begin sp <= sp - 1'b1; pc <= ir1; end
            OP_RET:  begin pc <= mem_rdata; sp <= sp + 1'b1; end
            OP_HLT:  state <= S_HALT;
            default: ;
          endcase
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assert_fetch_step_R1: assert property (@(posedge clk) disable iff (rst)
    (state == S_F0) |=> (pc == $past(pc) + 1'b1) && (state == S_F1));

  assert_write_ends_instr_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (state == S_F0));

  assert_push_step_R8: assert property (@(posedge clk) disable iff (rst)
    (in_ex && op == OP_CALL) |=> (sp == $past(sp) - 1'b1) && (pc == $past(ir1)));

  assert_pop_step_R8: assert property (@(posedge clk) disable iff (rst)
    (in_ex && op == OP_RET) |=> (sp == $past(sp) + 1'b1) && (pc == $past(mem_rdata)));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && !mem_we && $stable(pc));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(in_ex && is_alu) |=> $stable(flags));
endmodule

// File: tb/regfile_cpu_tb_top.sv
module regfile_cpu_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr, mem_rdata, mem_wdata;
  logic       mem_we, halted;

  always #5 clk = ~clk;

  regfile_cpu dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
  );

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  logic [7:0] mm [256];
  logic [7:0] m_rf [8];
  logic [7:0] m_pc, m_sp, m_i0, m_i1;
  logic [3:0] m_fl;
  int         m_ph;
  bit         m_halt;
  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] d);
    mem[a] = d; mm[a] = d;
  endtask

  task automatic ins(inout logic [7:0] a, input logic [3:0] op, input logic [3:0] lo, input logic [7:0] b1);
    put(a, {op, lo}); put(a + 8'd1, b1); a = a + 8'd2;
  endtask

  function automatic logic [7:0] rr(input int s1, input int s2);
    return {2'b00, s1[2:0], s2[2:0]};
  endfunction

  task automatic compare_now;
    logic [3:0] op;
    op = m_i0[7:4];
    if (m_halt) begin
      chk("R9 halted", {halted, mem_we}, 2'b10);
    end else if (m_ph < 2) begin
      chk("R1 fetch", {halted, mem_we, mem_addr}, {2'b00, m_pc});
    end else if (m_ph == 2) begin
      chk("R1 decode", {halted, mem_we}, 2'b00);
    end else begin
      case (op)
        4'd6:  chk("R5 load addr", {mem_we, mem_addr}, {1'b0, m_i1});
        4'd7:  chk("R5 store", {mem_we, mem_addr, mem_wdata}, {1'b1, m_i1, m_rf[m_i0[2:0]]});
        4'd11: chk("R8 push", {mem_we, mem_addr, mem_wdata}, {1'b1, m_sp - 8'd1, m_pc});
        4'd12: chk("R8 pop addr", {mem_we, mem_addr}, {1'b0, m_sp});
        default: chk("R1 exec no write", {halted, mem_we}, 2'b00);
      endcase
    end
  endtask

  task automatic step_model;
    logic [3:0] op;
    logic [7:0] a, b, r;
    logic [8:0] t;
    bit c, v, cf;
    if (m_halt) return;
    case (m_ph)
      0: begin m_i0 = mm[m_pc]; m_pc++; m_ph = 1; end
      1: begin m_i1 = mm[m_pc]; m_pc++; m_ph = 2; end
      2: m_ph = 3;
      default: begin
        m_ph = 0;
        op = m_i0[7:4];
        a = m_rf[m_i1[5:3]];
        b = m_rf[m_i1[2:0]];
        if (op <= 4'd4) begin
          c = 0; v = 0;
          if (op == 4'd0) begin
            t = a + b; r = t[7:0]; c = t[8];
            v = ($signed(a) + $signed(b) > 127) || ($signed(a) + $signed(b) < -128);
          end else if (op == 4'd1) begin
            r = a - b; c = a < b;
            v = ($signed(a) - $signed(b) > 127) || ($signed(a) - $signed(b) < -128);
          end else if (op == 4'd2) r = a & b;
          else if (op == 4'd3) r = a | b;
          else r = ~a;
          m_rf[m_i0[2:0]] = r;
          m_fl = {v, r[7], c, r == 8'd0};
        end else begin
          cf = m_fl[m_i0[1:0]];
          case (op)
            4'd5:  m_rf[m_i0[2:0]] = a;
            4'd6:  m_rf[m_i0[2:0]] = mm[m_i1];
            4'd7:  mm[m_i1] = m_rf[m_i0[2:0]];
            4'd8:  m_pc = m_i1;
            4'd9:  if (cf) m_pc = m_i1;
            4'd10: if (!cf) m_pc = m_i1;
            4'd11: begin m_sp--; mm[m_sp] = m_pc; m_pc = m_i1; end
            4'd12: begin m_pc = mm[m_sp]; m_sp++; end
            4'd15: m_halt = 1;
            default: ;
          endcase
        end
      end
    endcase
  endtask

  initial begin
    logic [7:0] pa;
    int after, cyc;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'hF0; mm[i] = 8'hF0; end
    for (int i = 8'hC0; i < 8'hF0; i++) put(i[7:0], 8'h00);
    put(8'hC0, 8'h7F); put(8'hC1, 8'h01); put(8'hC2, 8'hF0); put(8'hC3, 8'h3C);
    pa = 8'h00;
    ins(pa, 4'd6, 4'd1, 8'hC0);
    ins(pa, 4'd6, 4'd2, 8'hC1);
    ins(pa, 4'd0, 4'd3, rr(1, 2));
    ins(pa, 4'd7, 4'd3, 8'hD0);
    ins(pa, 4'd9, 4'd3, 8'h0C);
    ins(pa, 4'd15, 4'd0, 8'h00);
    ins(pa, 4'd1, 4'd4, rr(2, 1));
    ins(pa, 4'd7, 4'd4, 8'hD1);
    ins(pa, 4'd10, 4'd1, 8'h40);
    ins(pa, 4'd7, 4'd1, 8'hD2);
    ins(pa, 4'd6, 4'd5, 8'hC2);
    ins(pa, 4'd6, 4'd6, 8'hC3);
    ins(pa, 4'd2, 4'd7, rr(5, 6));
    ins(pa, 4'd10, 4'd1, 8'h1E);
    ins(pa, 4'd15, 4'd0, 8'h00);
    ins(pa, 4'd3, 4'd7, rr(5, 6));
    ins(pa, 4'd7, 4'd7, 8'hD3);
    ins(pa, 4'd4, 4'd0, rr(6, 0));
    ins(pa, 4'd5, 4'd1, rr(0, 0));
    ins(pa, 4'd9, 4'd2, 8'h2A);
    ins(pa, 4'd15, 4'd0, 8'h00);
    ins(pa, 4'd7, 4'd1, 8'hD4);
    ins(pa, 4'd11, 4'd0, 8'h50);
    ins(pa, 4'd7, 4'd2, 8'hD6);
    ins(pa, 4'd8, 4'd0, 8'h44);
    pa = 8'h44;
    ins(pa, 4'd7, 4'd3, 8'hD7);
    ins(pa, 4'd15, 4'd0, 8'h00);
    pa = 8'h50;
    ins(pa, 4'd1, 4'd2, rr(2, 2));
    ins(pa, 4'd9, 4'd0, 8'h56);
    ins(pa, 4'd15, 4'd0, 8'h00);
    ins(pa, 4'd12, 4'd0, 8'h00);

    for (int i = 0; i < 8; i++) m_rf[i] = 8'h00;
    m_pc = 8'h00; m_sp = 8'hFF; m_fl = 4'h0; m_ph = 0; m_halt = 0;

    repeat (3) @(negedge clk);
    chk("R2 reset outputs", {halted, mem_we, mem_addr}, 10'h000);
    rst = 1'b0;
    after = 0; cyc = 0;
    while (after < 8 && cyc < 2000) begin
      #1;
      compare_now();
      step_model();
      if (m_halt) after++;
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 2000) chk("watchdog R9", 1, 0);

    chk("R3 add result", mem[8'hD0], 8'h80);
    chk("R3 sub result", mem[8'hD1], 8'h82);
    chk("R7 fall-through store", mem[8'hD2], 8'h7F);
    chk("R4 or result", mem[8'hD3], 8'hFC);
    chk("R10 mov and flag kept", mem[8'hD4], 8'hC3);
    chk("R8 value after return", mem[8'hD6], 8'h00);
    chk("R8 return address on stack", mem[8'hFE], 8'h2E);
    chk("R6 jump target reached", mem[8'hD7], 8'h80);
    chk("R9 stays halted", halted, 1'b1);
    for (int i = 0; i < 256; i++)
      if (mem[i] !== mm[i]) chk("R5 memory image", {i[7:0], mem[i]}, {i[7:0], mm[i]});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule